// File: doc/BRIEF.md
# Double-Precision to Wrapped 32-bit Integer Converter

This block takes a 64-bit binary64 floating-point operand and turns it into a signed 32-bit integer with modulo 2^32 wrap-around rather than saturation. The value is always truncated toward zero. The low 32 bits of the exact, unbounded two's-complement integer are kept and then sign-extended to a parameterised integer width `XLEN`, which may be 32 or 64. The exception flags are the ones a saturating double-to-int32 conversion would raise for the same operand. A script engine's "truncate to int32" step is a typical user, since it wants wrapped values.

The caller presents an operand together with the instruction's rounding-mode field and its secondary-opcode field, and marks the cycle with `in_valid`. Two clock cycles later the block returns a registered result, a 5-bit flag vector and an illegal-encoding indication, marked by `out_valid`. Only one encoding is legal: selector 8 with rounding mode 1 (toward zero). Every other combination is reported as illegal and produces no result.

Top module: `f64_mod_i32`

## Requirements
- R1: `out_valid` equals `in_valid` delayed by exactly two clock cycles. The result and flags belong to the operand presented two cycles earlier. While reset is high, and in any cycle with `out_valid` low, `out_valid`, `result`, `flags` and `illegal` are all 0.
- R2: For a legal request with a finite operand, the result is bits 31:0 of the operand truncated toward zero. A negative operand gives the two's complement of the truncated magnitude. Those 32 bits are sign-extended to `XLEN`.
- R3: An infinity of either sign, or any NaN (quiet or signalling), gives result 0 with only the invalid flag set.
- R4: A finite operand whose truncated value lies outside [-2^31, 2^31-1] sets only the invalid flag. Its result is still the wrapped low 32 bits. -2^31 itself, and negative values that truncate to it, are in range.
- R5: An in-range finite operand with a nonzero fractional part sets only the inexact flag. An in-range operand that is already an integer sets no flag.
- R6: Positive or negative zero gives result 0 and no flags. A subnormal operand gives result 0 and sets only inexact.
- R7: An operand with magnitude 2^84 or more gives result 0 and sets only invalid.
- R8: A request is legal only when the selector is 8 and the rounding mode is 1. Any other combination sets `illegal` with result 0 and flags 0.
- R9: Flag vector layout: bit 4 invalid, bit 0 inexact, bits 3 to 1 always 0. Invalid and inexact are never set together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe for this cycle |
| operand | input | 64 | binary64 source value |
| rm_fld | input | 3 | Rounding-mode field of the instruction |
| op_sel | input | 5 | Secondary opcode (selector) field |
| out_valid | output | 1 | Result strobe, two cycles after `in_valid` |
| result | output | XLEN | Wrapped int32, sign-extended |
| flags | output | 5 | Exception flags (bit 4 invalid, bit 0 inexact) |
| illegal | output | 1 | Reserved encoding reported |

## Verification
Every result, flag vector and illegal indication is due exactly two rising edges after its request: one edge for the operand stage and one for the output register. The bench drives stimulus at falling edges and pushes one expected entry per cycle, idle cycles included, into a queue. At each falling edge it pops the entry queued two cycles earlier once the queue holds two entries, so every comparison lands on the cycle its result becomes visible. Back-to-back requests and gaps both run through this queue, so a one-cycle slip in `out_valid` or the data shows up as a mismatch.

// File: rtl/f64w_pkg.sv
package f64w_pkg;
  localparam int F64_W    = 64;
  localparam int EXP_W    = 11;
  localparam int FRAC_W   = 52;
  localparam int MANT_W   = FRAC_W + 1;
  localparam int EXP_BIAS = 1023;
  localparam int INT_W    = 32;
  // Beyond this left shift no integer bit below bit INT_W can be nonzero.
  localparam int MAX_SH   = INT_W + FRAC_W - 1;
  localparam int SH_W     = $clog2(MAX_SH + 1);
  localparam int WIDE_W   = MANT_W + MAX_SH;
  localparam int FLAG_W   = 5;
  localparam int FLG_NV   = 4;
  localparam int FLG_NX   = 0;
  localparam int RM_W     = 3;
  localparam int SEL_W    = 5;
  localparam logic [SEL_W-1:0] SEL_WRAP = 5'd8;
  localparam logic [RM_W-1:0]  RM_RTZ   = 3'd1;

  typedef enum logic [2:0] {
    CLS_ZERO = 3'd0,
    CLS_SUB  = 3'd1,
    CLS_NORM = 3'd2,
    CLS_INF  = 3'd3,
    CLS_NAN  = 3'd4
  } fcls_e;

  typedef struct packed {
    logic             valid;
    logic             illegal;
    logic             sign;
    fcls_e            cls;
    logic [INT_W-1:0] mag_lo;
    logic             frac_nz;
    logic             over;
    logic             neg_edge;
  } s1_t;
endpackage

// File: rtl/f64w_classify.sv
module f64w_classify
  import f64w_pkg::*;
(
  input  logic [F64_W-1:0]  operand,
  output logic              sign,
  output fcls_e             cls,
  output logic [MANT_W-1:0] mant,
  output logic [SH_W-1:0]   shamt,
  output logic              tiny,
  output logic              huge
);
  localparam logic [EXP_W-1:0] BIAS_V = EXP_W'(EXP_BIAS);
  localparam logic [EXP_W-1:0] HUGE_V = EXP_W'(EXP_BIAS + MAX_SH + 1);

  logic [EXP_W-1:0]  ex;
  logic [FRAC_W-1:0] fr;
  logic              ex_max;

  assign sign   = operand[F64_W-1];
  assign ex     = operand[F64_W-2 -: EXP_W];
  assign fr     = operand[FRAC_W-1:0];
  assign ex_max = (ex == '1);

  always_comb begin
    if (ex_max)         cls = (fr == '0) ? CLS_INF : CLS_NAN;
    else if (ex == '0)  cls = (fr == '0) ? CLS_ZERO : CLS_SUB;
    else                cls = CLS_NORM;
  end

  assign mant  = {(ex != '0), fr};
  assign tiny  = (ex < BIAS_V);
  assign huge  = (ex >= HUGE_V);
  assign shamt = (tiny || huge) ? '0 : SH_W'(ex - BIAS_V);
endmodule

// File: rtl/f64w_lshift.sv
module f64w_lshift #(
  parameter int IN_W  = 53,
  parameter int OUT_W = 136,
  parameter int SH_W  = 7
) (
  input  logic [IN_W-1:0]  din,
  input  logic [SH_W-1:0]  sh,
  output logic [OUT_W-1:0] dout
);
  logic [OUT_W-1:0] stg [0:SH_W];

  assign stg[0] = OUT_W'(din);

  for (genvar k = 0; k < SH_W; k++) begin : g_stage
    assign stg[k+1] = sh[k] ? (stg[k] << (1 << k)) : stg[k];
  end

  assign dout = stg[SH_W];
endmodule

// File: rtl/f64w_window.sv
module f64w_window
  import f64w_pkg::*;
(
  input  logic [WIDE_W-1:0] wide,
  input  logic              tiny,
  input  logic              huge,
  input  fcls_e             cls,
  output logic [INT_W-1:0]  mag_lo,
  output logic              frac_nz,
  output logic              over,
  output logic              neg_edge
);
  localparam int TOP_OK = FRAC_W + INT_W - 1;

  logic [INT_W-1:0] w_lo;
  logic             w_frac;
  logic             w_over;
  logic             w_edge;

  assign w_lo   = wide[FRAC_W +: INT_W];
  assign w_frac = |wide[FRAC_W-1:0];
  assign w_over = |wide[WIDE_W-1:TOP_OK];
  assign w_edge = wide[TOP_OK] && !(|wide[WIDE_W-1:TOP_OK+1])
                  && !(|wide[TOP_OK-1:FRAC_W]);

  always_comb begin
    if (tiny) begin
      mag_lo   = '0;
      frac_nz  = (cls != CLS_ZERO);
      over     = 1'b0;
      neg_edge = 1'b0;
    end else if (huge) begin
      mag_lo   = '0;
      frac_nz  = 1'b0;
      over     = 1'b1;
      neg_edge = 1'b0;
    end else begin
      mag_lo   = w_lo;
      frac_nz  = w_frac;
      over     = w_over;
      neg_edge = w_edge;
    end
  end
endmodule

// File: rtl/f64w_finish.sv
module f64w_finish
  import f64w_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  s1_t               s1,
  output logic [XLEN-1:0]   res,
  output logic [FLAG_W-1:0] flg,
  output logic              ill
);
  logic             special;
  logic             in_rng;
  logic             nv;
  logic             nx;
  logic [INT_W-1:0] low;

  assign special = (s1.cls == CLS_INF) || (s1.cls == CLS_NAN);
  assign in_rng  = !s1.over || (s1.sign && s1.neg_edge);
  assign nv      = special || !in_rng;
  assign nx      = !nv && s1.frac_nz;
  assign low     = s1.sign ? (~s1.mag_lo + 1'b1) : s1.mag_lo;

  always_comb begin
    res = '0;
    flg = '0;
    ill = 1'b0;
    if (s1.valid) begin
      if (s1.illegal) begin
        ill = 1'b1;
      end else begin
        flg[FLG_NV] = nv;
        flg[FLG_NX] = nx;
        if (!special) res = {{(XLEN-INT_W){low[INT_W-1]}}, low};
      end
    end
  end
endmodule

// File: rtl/f64_mod_i32.sv
module f64_mod_i32
  import f64w_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [63:0]       operand,
  input  logic [2:0]        rm_fld,
  input  logic [4:0]        op_sel,
  output logic              out_valid,
  output logic [XLEN-1:0]   result,
  output logic [4:0]        flags,
  output logic              illegal
);
  logic              c_sign;
  fcls_e             c_cls;
  logic [MANT_W-1:0] c_mant;
  logic [SH_W-1:0]   c_sh;
  logic              c_tiny;
  logic              c_huge;
  logic [WIDE_W-1:0] c_wide;
  logic [INT_W-1:0]  c_lo;
  logic              c_frac;
  logic              c_over;
  logic              c_edge;
  s1_t               s1_d;
  s1_t               s1_q;
  logic [XLEN-1:0]   f_res;
  logic [FLAG_W-1:0] f_flg;
  logic              f_ill;

  f64w_classify u_cls (
    .operand (operand),
    .sign    (c_sign),
    .cls     (c_cls),
    .mant    (c_mant),
    .shamt   (c_sh),
    .tiny    (c_tiny),
    .huge    (c_huge)
  );

  f64w_lshift #(.IN_W(MANT_W), .OUT_W(WIDE_W), .SH_W(SH_W)) u_sh (
    .din  (c_mant),
    .sh   (c_sh),
    .dout (c_wide)
  );

  f64w_window u_win (
    .wide     (c_wide),
    .tiny     (c_tiny),
    .huge     (c_huge),
    .cls      (c_cls),
    .mag_lo   (c_lo),
    .frac_nz  (c_frac),
    .over     (c_over),
    .neg_edge (c_edge)
  );

  always_comb begin
    s1_d          = '0;
    s1_d.cls      = CLS_ZERO;
    if (in_valid) begin
      s1_d.valid    = 1'b1;
      s1_d.illegal  = (op_sel != SEL_WRAP) || (rm_fld != RM_RTZ);
      s1_d.sign     = c_sign;
      s1_d.cls      = c_cls;
      s1_d.mag_lo   = c_lo;
      s1_d.frac_nz  = c_frac;
      s1_d.over     = c_over;
      s1_d.neg_edge = c_edge;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q     <= '0;
      s1_q.cls <= CLS_ZERO;
    end else begin
      s1_q <= s1_d;
    end
  end

  f64w_finish #(.XLEN(XLEN)) u_fin (
    .s1  (s1_q),
    .res (f_res),
    .flg (f_flg),
    .ill (f_ill)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      flags     <= '0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= s1_q.valid;
      result    <= f_res;
      flags     <= f_flg;
      illegal   <= f_ill;
    end
  end

  // R1: two-cycle latency of the strobe
  a_r1_latency_on: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ##1 out_valid);
  a_r1_latency_off: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ##1 !out_valid);
  // R3: specials give zero with invalid only
  a_r3_special_zero: assert property (@(posedge clk) disable iff (rst)
    (s1_q.valid && !s1_q.illegal && (s1_q.cls == CLS_INF || s1_q.cls == CLS_NAN))
    |=> (result == '0 && flags == 5'b10000));
  // R6: zero operand is silent
  a_r6_zero_quiet: assert property (@(posedge clk) disable iff (rst)
    (s1_q.valid && !s1_q.illegal && s1_q.cls == CLS_ZERO)
    |=> (result == '0 && flags == '0));
  // R8: reserved encodings produce nothing
  a_r8_illegal_quiet: assert property (@(posedge clk) disable iff (rst)
    (s1_q.valid && s1_q.illegal) |=> (illegal && result == '0 && flags == '0));
  // R9: flag layout
  a_r9_flag_layout: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (flags[3:1] == '0 && !(flags[4] && flags[0])));
  // R1: idle output cycles carry zeros
  a_r1_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (result == '0 && flags == '0 && !illegal));

  if (XLEN > INT_W) begin : g_sext_chk
    // R2: upper bits replicate bit 31
    a_r2_sign_ext: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (result[XLEN-1:INT_W] == {(XLEN-INT_W){result[INT_W-1]}}));
  end
endmodule

// File: tb/f64_mod_i32_tb.sv
`timescale 1ns/1ps
module f64_mod_i32_tb;
  localparam int XLEN = 64;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            in_valid = 1'b0;
  logic [63:0]     operand = '0;
  logic [2:0]      rm_fld = '0;
  logic [4:0]      op_sel = '0;
  logic            out_valid;
  logic [XLEN-1:0] result;
  logic [4:0]      flags;
  logic            illegal;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  f64_mod_i32 #(.XLEN(XLEN)) u_dut (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .operand   (operand),
    .rm_fld    (rm_fld),
    .op_sel    (op_sel),
    .out_valid (out_valid),
    .result    (result),
    .flags     (flags),
    .illegal   (illegal)
  );

  typedef struct packed {
    logic            v;
    logic            ill;
    logic [XLEN-1:0] res;
    logic [4:0]      fl;
    logic [23:0]     tag;
  } exp_t;

  exp_t q[$];

  // Behavioural reference built from the requirements.
  function automatic exp_t model(logic v, logic [63:0] op, logic [2:0] rm, logic [4:0] sel);
    exp_t e;
    int ex;
    int ub;
    longint unsigned mant;
    longint unsigned mag;
    logic frac;
    logic inr;
    logic [31:0] low;
    e = '0;
    e.tag = "R1";
    if (!v) return e;
    e.v = 1'b1;
    if (sel != 5'd8 || rm != 3'd1) begin e.ill = 1'b1; e.tag = "R8"; return e; end
    ex = int'(op[62:52]);
    if (ex == 2047) begin e.fl = 5'b10000; e.tag = "R3"; return e; end
    if (ex == 0) begin e.fl = (op[51:0] != 0) ? 5'b00001 : 5'b00000; e.tag = "R6"; return e; end
    ub = ex - 1023;
    if (ub >= 84) begin e.fl = 5'b10000; e.tag = "R7"; return e; end
    mant = {11'd0, 1'b1, op[51:0]};
    if (ub < 0) begin mag = 0; frac = 1'b1; end
    else if (ub <= 52) begin
      mag  = mant >> (52 - ub);
      frac = ((mant & ((64'd1 << (52 - ub)) - 64'd1)) != 0);
    end else begin
      mag  = mant << (ub - 52);
      frac = 1'b0;
    end
    inr = (ub <= 30) || (ub == 31 && op[63] && mag == 64'h8000_0000);
    low = op[63] ? (32'd0 - mag[31:0]) : mag[31:0];
    e.res = {{(XLEN-32){low[31]}}, low};
    if (!inr) begin e.fl = 5'b10000; e.tag = "R4"; end
    else if (frac) begin e.fl = 5'b00001; e.tag = "R5"; end
    else e.tag = "R2";
    return e;
  endfunction

  task automatic compare(exp_t e);
    checks++;
    if (out_valid !== e.v || illegal !== e.ill || result !== e.res || flags !== e.fl) begin
      errors++;
      $display("FAIL %s: got v=%0b ill=%0b res=%h fl=%b, expected v=%0b ill=%0b res=%h fl=%b",
               e.tag, out_valid, illegal, result, flags, e.v, e.ill, e.res, e.fl);
    end
  endtask

  task automatic step(logic v, logic [63:0] op, logic [2:0] rm, logic [4:0] sel);
    @(negedge clk);
    if (q.size() >= 2) compare(q.pop_front());
    in_valid = v;
    operand  = op;
    rm_fld   = rm;
    op_sel   = sel;
    q.push_back(model(v, op, rm, sel));
  endtask

  task automatic go(logic [63:0] op);
    step(1'b1, op, 3'd1, 5'd8);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    longint unsigned r;
    r = 64'h9E37_79B9_7F4A_7C15;
    repeat (4) @(negedge clk);
    // R1: reset state
    checks++;
    if (out_valid !== 1'b0 || result !== '0 || flags !== '0 || illegal !== 1'b0) begin
      errors++;
      $display("FAIL R1: reset got v=%0b res=%h fl=%b ill=%0b, expected all 0",
               out_valid, result, flags, illegal);
    end
    rst = 1'b0;

    // R2 exact values, both signs
    go(64'h3FF0_0000_0000_0000);
    go(64'hBFF0_0000_0000_0000);
    go(64'h41DF_FFFF_FFC0_0000);
    go(64'hC1E0_0000_0000_0000);
    step(1'b0, '0, '0, '0);
    // R5 fractions
    go(64'h4004_0000_0000_0000);
    go(64'hC004_0000_0000_0000);
    go(64'hC1E0_0000_0010_0000);
    go(64'h3FE0_0000_0000_0000);
    go(64'hBFE8_0000_0000_0000);
    // R4 out of range but wrapped
    go(64'h41E0_0000_0000_0000);
    go(64'h41F0_0000_0050_0000);
    go(64'h4330_0000_0000_0003);
    go(64'hC330_0000_0000_0003);
    go(64'hC1E0_0000_0020_0000);
    // R7 huge magnitudes
    go(64'h4530_0000_0000_0000);
    go(64'hC52F_FFFF_FFFF_FFFF);
    go(64'h4520_0000_0000_0001);
    // R3 specials
    go(64'h7FF0_0000_0000_0000);
    go(64'hFFF0_0000_0000_0000);
    go(64'h7FF8_0000_0000_0000);
    go(64'h7FF0_0000_0000_0001);
    // R6 zero and subnormal
    go(64'h0000_0000_0000_0000);
    go(64'h8000_0000_0000_0000);
    go(64'h0000_0000_0000_0001);
    go(64'h800F_FFFF_FFFF_FFFF);
    // R8 reserved encodings
    step(1'b1, 64'h3FF0_0000_0000_0000, 3'd0, 5'd8);
    step(1'b1, 64'h3FF0_0000_0000_0000, 3'd1, 5'd7);
    step(1'b1, 64'h7FF8_0000_0000_0000, 3'd7, 5'd8);
    step(1'b0, 64'h3FF0_0000_0000_0000, 3'd1, 5'd8);

    // R2 R4 R5 R7: mixed pseudo-random operands around the integer range
    for (int i = 0; i < 400; i++) begin
      logic [63:0] op;
      r = r ^ (r << 13);
      r = r ^ (r >> 7);
      r = r ^ (r << 17);
      if (r[60]) op = {r[63], 11'(1000 + (r[59:52] % 8'd96)), r[51:0]};
      else       op = r;
      if (r[2:0] == 3'd0) step(1'b0, op, 3'd1, 5'd8);
      else if (r[5:3] == 3'd0) step(1'b1, op, r[8:6], 5'd8);
      else go(op);
    end

    step(1'b0, '0, '0, '0);
    step(1'b0, '0, '0, '0);
    step(1'b0, '0, '0, '0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule